// File: doc/BRIEF.md
# Six-Channel Thyristor Firing Pulse Generator

This block produces the gate firing pulses for a three-phase, six-thyristor full-wave bridge. Each of the six channels owns a cycle counter. The counter restarts at that channel's zero-crossing reference. The channel's output goes high when the counter reaches a programmed delay count. It goes low again at a programmed end count, which is normally set to the 120-degree point. A later firing angle therefore gives a narrower pulse, because the end point does not move.

Zero crossings come from one of two sources:
- Three external square waves, one per phase. A rising edge marks the positive half of that phase and a falling edge marks the negative half.
- A free-running internal three-phase reference whose period is set by a parameter (2,000,000 cycles, which is 50 Hz at 100 MHz).

Software loads a delay count and an end count through a simple write port. It can also set a mode bit that adds a 30-degree offset to the delay. Each channel takes a private copy of these settings at its own zero crossing. A change made mid-period therefore never clips or doubles a pulse.

Top module: `thy_fire_gen`

## Requirements
- R1: A synchronous active-low reset clears the holding registers, every channel counter and the internal reference. `fire` is all zeros in the cycle after the reset edge. `fire` stays zero after release until a new zero crossing arrives.
- R2: With `ref_sel`=0, each bit of `ac_sq` drives its own channels:
  - A rising edge of bit 0 starts channel T1 (`fire[0]`), and its falling edge starts T4 (`fire[3]`).
  - A rising edge of bit 1 starts T3 (`fire[2]`), and its falling edge starts T6 (`fire[5]`).
  - A rising edge of bit 2 starts T5 (`fire[4]`), and its falling edge starts T2 (`fire[1]`).
  - No other output reacts to these edges.
- R3: The effective delay count is D. A channel's output is first high 3 + D cycles after the clock edge that captures the external input edge (two synchronizer stages plus the counter start).
- R4: The output first returns low 3 + E cycles after that edge, where E is the end count. The pulse width is therefore E − D cycles.
- R5: When the neutral-reference bit is 1, D equals the delay register plus PERIOD/12 (30 degrees). Otherwise D equals the delay register.
- R6: If D ≥ E, the channel produces no pulse at all for that period.
- R7: Register and mode-bit changes take effect only at a channel's next zero crossing. A pulse already in progress keeps its old rise and end points.
- R8: With `ref_sel`=1, the internal reference has a period of PERIOD cycles. Channels T1..T6 start in that order, PERIOD/6 cycles apart. Each channel repeats once per PERIOD.
- R9: A write with `wr_sel`=0 loads the delay register and a write with `wr_sel`=1 loads the end register. The write is visible from the next cycle.
- R10: After a zero crossing the counter stops at the end count. A channel fires exactly once per zero crossing and stays low until the next crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_sel | input | 1 | 0: external square waves, 1: internal reference |
| ac_sq | input | 3 | External per-phase square waves (asynchronous) |
| neutral_ref | input | 1 | 1 adds a 30-degree offset to the delay |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: delay register, 1: end register |
| wr_data | input | CW | Write data |
| fire | output | 6 | Gate pulses T1..T6 (bit 0 = T1) |

## Verification
The hardest case to reach from the ports is a register update that lands while a pulse is high. The stimulus has to place the write strictly between a channel's rise and its fall. The bench starts one channel from a single square-wave edge and waits inside the pulse before writing new counts. It then checks that the pulse still ends at the old count. Finally it produces the opposite edge and checks that the partner channel uses the new counts. Exact edge timing comes from driving phase edges by hand. The bench parameter shortens the period so that the internal-reference spacing check fits in a few mains periods.

// File: rtl/thy_fire_pkg.sv
// Package: shared constants and the channel-to-phase map of the bridge.
// Assumes the usual firing order T1..T6 with phases A, B, C lagging by 120 degrees.
package thy_fire_pkg;
    localparam int NUM_PHASES = 3;
    localparam int NUM_CH     = 6;

    // Phase whose edge starts channel k (T1=A+, T2=C-, T3=B+, T4=A-, T5=C+, T6=B-).
    function automatic int ch_phase(input int k);
        if ((k % 2) == 0) return k / 2;
        return ((k / 2) + 2) % 3;
    endfunction

    // Even channels start on a rising edge, odd ones on a falling edge.
    function automatic bit ch_on_rise(input int k);
        return (k % 2) == 0;
    endfunction
endpackage

// File: rtl/thy_fire_ref_gen.sv
// Internal three-phase reference: a phase counter over PERIOD cycles and three
// square waves whose edges fall on multiples of PERIOD/6.
// Assumes PERIOD >= 12; spacing is exact when PERIOD is a multiple of 6.
module thy_fire_ref_gen
    import thy_fire_pkg::*;
#(
    parameter int PERIOD = 2000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] sq
);
    localparam int PW = $clog2(PERIOD);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
    localparam logic [PW-1:0] S1   = PW'(PERIOD / 6);
    localparam logic [PW-1:0] S2   = PW'(2 * (PERIOD / 6));
    localparam logic [PW-1:0] S3   = PW'(3 * (PERIOD / 6));
    localparam logic [PW-1:0] S4   = PW'(4 * (PERIOD / 6));
    localparam logic [PW-1:0] S5   = PW'(5 * (PERIOD / 6));

    logic [PW-1:0] ph;

    // Phase counter wrapping once per mains period.
    always_ff @(posedge clk) begin
        if (!rst_n)          ph <= '0;
        else if (ph == LAST) ph <= '0;
        else                 ph <= ph + PW'(1);
    end

    // Square waves: A high over [0,3S), B over [2S,5S), C over [4S,S) wrapped.
    always_comb begin
        sq[0] = (ph < S3);
        sq[1] = (ph >= S2) && (ph < S5);
        sq[2] = (ph >= S4) || (ph < S1);
    end

    p_phase_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= LAST);
    p_phase_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == LAST) |=> (ph == '0));
endmodule

// File: rtl/thy_fire_zc_detect.sv
// Zero-crossing front end: synchronizes the external square waves, selects the
// reference source and turns edges into one-cycle start strobes per channel.
// Assumes the external inputs are asynchronous and slow compared with clk.
module thy_fire_zc_detect
    import thy_fire_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_sel,
    input  logic [NUM_PHASES-1:0] ext_sq,
    input  logic [NUM_PHASES-1:0] int_sq,
    output logic [NUM_CH-1:0]     zc
);
    logic [NUM_PHASES-1:0] sync_q [SYNC_STAGES];
    logic [NUM_PHASES-1:0] src, prev, up, dn;

    // Synchronizer chain for the external waves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= ext_sq;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    // Source select between external and internal reference.
    assign src = ref_sel ? int_sq : sync_q[SYNC_STAGES-1];

    // Previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= src;
    end

    assign up = src & ~prev;
    assign dn = ~src & prev;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_map
        localparam int PH = ch_phase(k);
        if (ch_on_rise(k)) begin : g_up
            assign zc[k] = up[PH];
        end else begin : g_dn
            assign zc[k] = dn[PH];
        end
        p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            zc[k] |=> !zc[k]);
    end
endmodule

// File: rtl/thy_fire_channel.sv
// One firing channel: restarts its counter at its zero crossing, latches the
// timing settings there, and drives its pulse between delay and end counts.
// Assumes zc is a one-cycle strobe; the counter stops at the end count.
module thy_fire_channel #(
    parameter int CW     = 32,
    parameter int PERIOD = 2000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zc,
    input  logic [CW-1:0] rise_in,
    input  logic [CW-1:0] fall_in,
    input  logic          neutral_in,
    output logic          fire
);
    localparam logic [CW:0] OFS_V = (CW+1)'(PERIOD / 12);

    logic [CW-1:0] cnt;
    logic [CW-1:0] fall_sh;
    logic [CW:0]   rise_sh;
    logic          run;

    // Counter and shadow capture, restarted at each zero crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            fall_sh <= '0;
            rise_sh <= '0;
            run     <= 1'b0;
        end else if (zc) begin
            cnt     <= '0;
            run     <= 1'b1;
            fall_sh <= fall_in;
            rise_sh <= {1'b0, rise_in} + (neutral_in ? OFS_V : '0);
        end else if (run && (cnt < fall_sh)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Pulse window between the delay and end counts.
    assign fire = run && ({1'b0, cnt} >= rise_sh) && (cnt < fall_sh);

    p_rise_at_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire) |-> (rise_sh == {1'b0, cnt}));
    p_fall_at_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fire) |-> ((cnt == fall_sh) || $past(zc) || !$past(rst_n)));
    p_no_pulse_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (rise_sh >= {1'b0, fall_sh})) |-> !fire);
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !zc) |=> ($stable(rise_sh) && $stable(fall_sh)));
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= fall_sh));
endmodule

// File: rtl/thy_fire_gen.sv
// Top: holding registers for the delay and end counts, reference source,
// zero-crossing detection and six firing channels T1..T6.
// Assumes software writes counts already converted from degrees.
module thy_fire_gen
    import thy_fire_pkg::*;
#(
    parameter int CW          = 32,
    parameter int PERIOD      = 2000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_sel,
    input  logic [NUM_PHASES-1:0] ac_sq,
    input  logic                  neutral_ref,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [CW-1:0]         wr_data,
    output logic [NUM_CH-1:0]     fire
);
    logic [CW-1:0]         rise_q, fall_q;
    logic [NUM_PHASES-1:0] int_sq;
    logic [NUM_CH-1:0]     zc;

    // Holding registers loaded by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) fall_q <= wr_data;
            else        rise_q <= wr_data;
        end
    end

    thy_fire_ref_gen #(.PERIOD(PERIOD)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .sq    (int_sq)
    );

    thy_fire_zc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_zc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_sel (ref_sel),
        .ext_sq  (ac_sq),
        .int_sq  (int_sq),
        .zc      (zc)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        thy_fire_channel #(.CW(CW), .PERIOD(PERIOD)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .zc         (zc[k]),
            .rise_in    (rise_q),
            .fall_in    (fall_q),
            .neutral_in (neutral_ref),
            .fire       (fire[k])
        );
    end

    p_write_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (rise_q == $past(wr_data)));
    p_write_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (fall_q == $past(wr_data)));
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (fire == '0));
endmodule

// File: tb/thy_fire_gen_test.sv
module thy_fire_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 1200;
    localparam int CW   = 32;
    localparam int LAT  = 3;
    localparam int OFS  = P / 12;
    localparam int SIX  = P / 6;
    localparam int NVEC = 7;
    // Each row: delay count, end count, neutral bit.
    localparam int VEC [NVEC][3] = '{
        '{33, 400, 0}, '{166, 400, 0}, '{300, 400, 0}, '{33, 400, 1},
        '{300, 400, 1}, '{0, 400, 0}, '{500, 400, 0}};

    logic          clk = 1'b0;
    logic          rst_n, ref_sel, neutral_ref, wr_en, wr_sel;
    logic [2:0]    ac_sq;
    logic [CW-1:0] wr_data;
    logic [5:0]    fire;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int rise_at [6], fall_at [6], prev_rise [6], nrise [6];
    logic [5:0] fprev = '0;

    thy_fire_gen #(.CW(CW), .PERIOD(P)) uut (
        .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .ac_sq(ac_sq),
        .neutral_ref(neutral_ref), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fire(fire));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor sampled away from the active edge.
    always @(negedge clk) begin
        for (int k = 0; k < 6; k++) begin
            if (fire[k] && !fprev[k]) begin
                prev_rise[k] = rise_at[k];
                rise_at[k]   = cyc;
                nrise[k]     = nrise[k] + 1;
            end
            if (!fire[k] && fprev[k]) fall_at[k] = cyc;
        end
        fprev = fire;
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = CW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sq(input int p, input bit v, output int c);
        @(negedge clk);
        ac_sq[p] = v;
        c = cyc;
    endtask

    function automatic int pmod(input int a);
        return ((a % P) + P) % P;
    endfunction

    // Check one pulse started by an edge at cycle c with delay d and end e.
    task automatic check_pulse(input int ch, input int c, input int d, input int e,
                               input int n0, input string tag);
        if (d < e) begin
            chk(nrise[ch] == n0 + 1, {tag, " one pulse (R10)"}, nrise[ch] - n0, 1);
            chk(rise_at[ch] == c + LAT + d, {tag, " rise cycle (R3)"}, rise_at[ch], c + LAT + d);
            chk(fall_at[ch] == c + LAT + e, {tag, " fall cycle (R4)"}, fall_at[ch], c + LAT + e);
        end else begin
            chk(nrise[ch] == n0, {tag, " no pulse (R6)"}, nrise[ch] - n0, 0);
        end
        chk(fire[ch] == 1'b0, {tag, " idle after end (R10)"}, int'(fire[ch]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired (R1..all): actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c, c2, n0, d;
        int up_ch [3] = '{0, 2, 4};
        int dn_ch [3] = '{3, 5, 1};
        int snap [6];
        for (int k = 0; k < 6; k++) begin
            rise_at[k] = 0; fall_at[k] = 0; prev_rise[k] = 0; nrise[k] = 0;
        end
        rst_n = 1'b0; ref_sel = 1'b0; neutral_ref = 1'b0; ac_sq = '0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        idle(5);
        chk(fire == '0, "R1 outputs low in reset", int'(fire), 0);
        rst_n = 1'b1;
        idle(3);
        chk(fire == '0, "R1 outputs low after release", int'(fire), 0);

        // Table walk: phase A edges start T1 then T4 (R2, R3, R4, R5, R6, R9).
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b0, VEC[i][0]);
            wr(1'b1, VEC[i][1]);
            neutral_ref = VEC[i][2][0];
            idle(2);
            d = VEC[i][0] + (VEC[i][2] != 0 ? OFS : 0);
            n0 = nrise[0];
            set_sq(0, 1'b1, c);
            idle(700);
            check_pulse(0, c, d, VEC[i][1], n0, "R5 T1");
            n0 = nrise[3];
            set_sq(0, 1'b0, c);
            idle(700);
            check_pulse(3, c, d, VEC[i][1], n0, "R2 T4");
        end
        neutral_ref = 1'b0;

        // Channel map for phases B and C (R2).
        wr(1'b0, 10);
        wr(1'b1, 50);
        idle(2);
        for (int p = 1; p < 3; p++) begin
            for (int k = 0; k < 6; k++) snap[k] = nrise[k];
            set_sq(p, 1'b1, c);
            idle(100);
            chk(rise_at[up_ch[p]] == c + LAT + 10, "R2 rising edge channel", rise_at[up_ch[p]], c + LAT + 10);
            for (int k = 0; k < 6; k++)
                chk(nrise[k] - snap[k] == (k == up_ch[p] ? 1 : 0), "R2 only mapped channel",
                    nrise[k] - snap[k], (k == up_ch[p] ? 1 : 0));
            for (int k = 0; k < 6; k++) snap[k] = nrise[k];
            set_sq(p, 1'b0, c);
            idle(100);
            chk(rise_at[dn_ch[p]] == c + LAT + 10, "R2 falling edge channel", rise_at[dn_ch[p]], c + LAT + 10);
            for (int k = 0; k < 6; k++)
                chk(nrise[k] - snap[k] == (k == dn_ch[p] ? 1 : 0), "R2 only mapped channel",
                    nrise[k] - snap[k], (k == dn_ch[p] ? 1 : 0));
        end

        // Update during a live pulse (R7).
        wr(1'b0, 33);
        wr(1'b1, 400);
        idle(2);
        set_sq(0, 1'b1, c);
        idle(50);
        wr(1'b0, 200);
        wr(1'b1, 250);
        idle(600);
        chk(rise_at[0] == c + LAT + 33, "R7 live pulse keeps rise", rise_at[0], c + LAT + 33);
        chk(fall_at[0] == c + LAT + 400, "R7 live pulse keeps end", fall_at[0], c + LAT + 400);
        set_sq(0, 1'b0, c2);
        idle(600);
        chk(rise_at[3] == c2 + LAT + 200, "R7 next crossing new rise", rise_at[3], c2 + LAT + 200);
        chk(fall_at[3] == c2 + LAT + 250, "R7 next crossing new end", fall_at[3], c2 + LAT + 250);

        // Reset in the middle of a pulse (R1).
        wr(1'b0, 0);
        wr(1'b1, 400);
        idle(2);
        set_sq(2, 1'b1, c);
        idle(20);
        chk(fire[4] == 1'b1, "R1 T5 high before reset", int'(fire[4]), 1);
        rst_n = 1'b0;
        ac_sq = '0;
        @(negedge clk);
        chk(fire == '0, "R1 reset clears live pulse", int'(fire), 0);
        rst_n = 1'b1;
        n0 = nrise[4];
        idle(100);
        chk(nrise[4] == n0 && fire == '0, "R1 quiet until next crossing", nrise[4] - n0, 0);

        // Internal reference (R8).
        wr(1'b0, 33);
        wr(1'b1, 400);
        ref_sel = 1'b1;
        idle(3700);
        for (int k = 0; k < 6; k++) begin
            chk(pmod(rise_at[(k + 1) % 6] - rise_at[k]) == SIX, "R8 channel spacing",
                pmod(rise_at[(k + 1) % 6] - rise_at[k]), SIX);
            chk(pmod(fall_at[k] - rise_at[k]) == 367, "R8 internal width (R4)",
                pmod(fall_at[k] - rise_at[k]), 367);
        end
        chk(rise_at[0] - prev_rise[0] == P, "R8 repeat period", rise_at[0] - prev_rise[0], P);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule